// File: doc/BRIEF.md
# March C- Self-Test Sequencer with Word-Line-Major Addressing

This block is a built-in self-test sequencer for a synchronous single-port memory. On a start pulse it runs the six-element March C- algorithm. It drives address, write data, write enable and read enable, issuing one memory operation per clock. It compares every read result against the value the algorithm expects.

The address counter walks the array one word line at a time. Every word of a word line is visited before the sequencer moves to the next word line. Ascending elements begin at word 0 of word line 0. Descending elements begin at the last word of the last word line. Because of this order, the same-row access stress falls on every cell between the write that sensitises it and the read that observes it. The order adds no operations, so a full run is exactly ten operations per word.

A sticky fail flag reports any miscompare. With it, the sequencer holds the address, the element index and the expected word of the first failing read. A one-cycle done pulse closes the run.

Top module: `march_bist_ctrl`

## Requirements
- R1: A run executes six elements in this order, numbered 0 to 5: element 0 writes 0; elements 1 and 3 read 0, then write 1; elements 2 and 4 read 1, then write 0; element 5 reads 0. Within an element, all operations on one address finish before the address changes.
- R2: After an accepted start, operations are issued on consecutive clocks with no idle cycle. A run contains exactly 10 × ROW_N × COL_N operations.
- R3: Elements 0, 1, 2 and 5 run in ascending order. The column index counts 0 to COL_N-1 inside a word line before the word-line index advances. The address is {word line, column}, with the column in the low $clog2(COL_N) bits.
- R4: Elements 3 and 4 run in descending order. They begin at word line ROW_N-1, column COL_N-1, and step the column down before moving to the lower word line.
- R5: Read data is compared one cycle after the read is issued. The expected value is all zeros for a "read 0" and all ones for a "read 1". Any difference sets fail_o.
- R6: fail_o is sticky until the next accepted start, which clears it. fail_addr_o, fail_elem_o and fail_exp_o hold the address, the element index and the expected word of the first miscompare, and later miscompares do not change them.
- R7: done_o is high for exactly one cycle, two cycles after the final read was issued. In that cycle busy_o is low and fail_o already reflects the final compare.
- R8: A start pulse while busy_o is high is ignored. The operation stream continues unchanged.
- R9: During and just after reset, busy_o, done_o, fail_o, mem_we_o and mem_re_o are low.
- R10: mem_we_o and mem_re_o are never high together. Write data is always all zeros or all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| mem_addr_o | output | ADDR_W | Memory address {word line, column} |
| mem_wdata_o | output | DW | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read enable |
| mem_rdata_i | input | DW | Read data, valid one cycle after mem_re_o |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | Sticky miscompare flag |
| fail_addr_o | output | ADDR_W | Address of first miscompare |
| fail_elem_o | output | 3 | Element index of first miscompare |
| fail_exp_o | output | DW | Expected word of first miscompare |

## Verification
The hardest situation to reach is the capture of the first miscompare while later miscompares keep arriving. The bench brings it about with a memory model that forces bits on selected words when they are read. Two faulty words at different addresses must leave only the lower one captured. A stuck-at-0 bit escapes the read-0 elements and must be caught first by element 2, with an expected word of all ones. A start pulse injected in the middle of a run checks that the full operation stream, compared item by item against an independently generated list, stays unchanged.

// File: rtl/march_pkg.sv
package march_pkg;

  localparam int ELEM_N = 6;
  localparam int ELEM_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2,
    ST_FIN   = 2'd3
  } seq_st_e;

  // Per-element configuration of the March C- algorithm
  typedef struct packed {
    logic two_ops;    // element has a read followed by a write
    logic op0_write;  // first operation is a write
    logic descend;    // element walks addresses downward
    logic first_val;  // data value of the first operation
  } elem_cfg_t;

  function automatic elem_cfg_t elem_cfg(logic [ELEM_W-1:0] e);
    elem_cfg_t c;
    case (e)
      3'd0:    c = '{two_ops: 1'b0, op0_write: 1'b1, descend: 1'b0, first_val: 1'b0};
      3'd1:    c = '{two_ops: 1'b1, op0_write: 1'b0, descend: 1'b0, first_val: 1'b0};
      3'd2:    c = '{two_ops: 1'b1, op0_write: 1'b0, descend: 1'b0, first_val: 1'b1};
      3'd3:    c = '{two_ops: 1'b1, op0_write: 1'b0, descend: 1'b1, first_val: 1'b0};
      3'd4:    c = '{two_ops: 1'b1, op0_write: 1'b0, descend: 1'b1, first_val: 1'b1};
      default: c = '{two_ops: 1'b0, op0_write: 1'b0, descend: 1'b0, first_val: 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/march_addr_gen.sv
module march_addr_gen #(
  parameter int ROW_N = 512,
  parameter int COL_N = 16,
  localparam int ROW_W = (ROW_N > 1) ? $clog2(ROW_N) : 1,
  localparam int COL_W = (COL_N > 1) ? $clog2(COL_N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             load_down_i,
  input  logic             step_i,
  input  logic             down_i,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic             end_o
);

  localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(ROW_N - 1);
  localparam logic [COL_W-1:0] COL_MAX = COL_W'(COL_N - 1);

  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             upd;

  always_comb begin
    row_d = row_q;
    col_d = col_q;
    upd   = load_i | step_i;
    if (load_i) begin
      row_d = load_down_i ? ROW_MAX : '0;
      col_d = load_down_i ? COL_MAX : '0;
    end else if (step_i) begin
      if (down_i) begin
        if (col_q == '0) begin
          col_d = COL_MAX;
          row_d = row_q - 1'b1;
        end else begin
          col_d = col_q - 1'b1;
        end
      end else begin
        if (col_q == COL_MAX) begin
          col_d = '0;
          row_d = row_q + 1'b1;
        end else begin
          col_d = col_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (upd) begin
      row_q <= row_d;
      col_q <= col_d;
    end
  end

  assign row_o = row_q;
  assign col_o = col_q;
  assign end_o = down_i ? ((row_q == '0) && (col_q == '0))
                        : ((row_q == ROW_MAX) && (col_q == COL_MAX));

endmodule

// File: rtl/march_seq.sv
module march_seq
  import march_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              addr_end_i,
  output logic              ag_load_o,
  output logic              ag_load_down_o,
  output logic              ag_step_o,
  output logic              ag_down_o,
  output logic              iss_vld_o,
  output logic              iss_we_o,
  output logic              iss_val_o,
  output logic [ELEM_W-1:0] elem_o,
  output logic              clr_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam logic [ELEM_W-1:0] LAST_ELEM = ELEM_W'(ELEM_N - 1);

  seq_st_e           st_q, st_d;
  logic [ELEM_W-1:0] elem_q, elem_d;
  logic              op_q, op_d;
  elem_cfg_t         cfg, cfg_next;
  logic              last_op;

  always_comb begin
    cfg      = elem_cfg(elem_q);
    cfg_next = elem_cfg(elem_q + 1'b1);
    st_d     = st_q;
    elem_d   = elem_q;
    op_d     = op_q;
    ag_load_o      = 1'b0;
    ag_load_down_o = 1'b0;
    ag_step_o      = 1'b0;
    iss_vld_o      = 1'b0;
    clr_o          = 1'b0;
    iss_we_o  = op_q | cfg.op0_write;
    iss_val_o = op_q ? ~cfg.first_val : cfg.first_val;
    last_op   = cfg.two_ops ? op_q : 1'b1;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d      = ST_RUN;
          elem_d    = '0;
          op_d      = 1'b0;
          ag_load_o = 1'b1;
          clr_o     = 1'b1;
        end
      end
      ST_RUN: begin
        iss_vld_o = 1'b1;
        if (!last_op) begin
          op_d = 1'b1;
        end else begin
          op_d = 1'b0;
          if (!addr_end_i) begin
            ag_step_o = 1'b1;
          end else if (elem_q == LAST_ELEM) begin
            st_d = ST_FLUSH;
          end else begin
            elem_d         = elem_q + 1'b1;
            ag_load_o      = 1'b1;
            ag_load_down_o = cfg_next.descend;
          end
        end
      end
      ST_FLUSH: st_d = ST_FIN;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      elem_q <= '0;
      op_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      elem_q <= elem_d;
      op_q   <= op_d;
    end
  end

  assign ag_down_o = cfg.descend;
  assign elem_o    = elem_q;
  assign busy_o    = (st_q == ST_RUN) || (st_q == ST_FLUSH);
  assign done_o    = (st_q == ST_FIN);

endmodule

// File: rtl/march_cmp.sv
module march_cmp
  import march_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              rd_iss_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [ELEM_W-1:0] elem_i,
  input  logic              exp_i,
  input  logic [DW-1:0]     rdata_i,
  output logic              fail_o,
  output logic [AW-1:0]     fail_addr_o,
  output logic [ELEM_W-1:0] fail_elem_o,
  output logic              fail_exp_o
);

  logic              p_vld_q;
  logic [AW-1:0]     p_addr_q;
  logic [ELEM_W-1:0] p_elem_q;
  logic              p_exp_q;
  logic              p_en;

  logic              fail_q;
  logic [AW-1:0]     f_addr_q;
  logic [ELEM_W-1:0] f_elem_q;
  logic              f_exp_q;
  logic              miscmp, cap_en;

  assign p_en   = rd_iss_i;
  assign miscmp = p_vld_q && (rdata_i != {DW{p_exp_q}});
  assign cap_en = miscmp && !fail_q && !clr_i;

  // Tag stage: follows the read into the memory's output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_vld_q <= 1'b0;
    end else begin
      p_vld_q <= rd_iss_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_addr_q <= '0;
      p_elem_q <= '0;
      p_exp_q  <= 1'b0;
    end else if (p_en) begin
      p_addr_q <= addr_i;
      p_elem_q <= elem_i;
      p_exp_q  <= exp_i;
    end
  end

  // Sticky flag and first-failure capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
    end else if (clr_i) begin
      fail_q <= 1'b0;
    end else if (miscmp) begin
      fail_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_addr_q <= '0;
      f_elem_q <= '0;
      f_exp_q  <= 1'b0;
    end else if (clr_i) begin
      f_addr_q <= '0;
      f_elem_q <= '0;
      f_exp_q  <= 1'b0;
    end else if (cap_en) begin
      f_addr_q <= p_addr_q;
      f_elem_q <= p_elem_q;
      f_exp_q  <= p_exp_q;
    end
  end

  assign fail_o      = fail_q;
  assign fail_addr_o = f_addr_q;
  assign fail_elem_o = f_elem_q;
  assign fail_exp_o  = f_exp_q;

endmodule

// File: rtl/march_bist_ctrl.sv
module march_bist_ctrl
  import march_pkg::*;
#(
  parameter int ROW_N = 512,
  parameter int COL_N = 16,
  parameter int DW    = 32,
  localparam int ROW_W  = (ROW_N > 1) ? $clog2(ROW_N) : 1,
  localparam int COL_W  = (COL_N > 1) ? $clog2(COL_N) : 1,
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [2:0]        fail_elem_o,
  output logic [DW-1:0]     fail_exp_o
);

  logic             ag_load, ag_load_down, ag_step, ag_down, ag_end;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic             iss_vld, iss_we, iss_val, clr;
  logic [ELEM_W-1:0] elem;
  logic             f_exp;

  march_addr_gen #(
    .ROW_N (ROW_N),
    .COL_N (COL_N)
  ) addr_gen_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (ag_load),
    .load_down_i (ag_load_down),
    .step_i      (ag_step),
    .down_i      (ag_down),
    .row_o       (row),
    .col_o       (col),
    .end_o       (ag_end)
  );

  march_seq seq_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .addr_end_i     (ag_end),
    .ag_load_o      (ag_load),
    .ag_load_down_o (ag_load_down),
    .ag_step_o      (ag_step),
    .ag_down_o      (ag_down),
    .iss_vld_o      (iss_vld),
    .iss_we_o       (iss_we),
    .iss_val_o      (iss_val),
    .elem_o         (elem),
    .clr_o          (clr),
    .busy_o         (busy_o),
    .done_o         (done_o)
  );

  assign mem_addr_o  = {row, col};
  assign mem_we_o    = iss_vld & iss_we;
  assign mem_re_o    = iss_vld & ~iss_we;
  assign mem_wdata_o = {DW{iss_val}};

  march_cmp #(
    .DW (DW),
    .AW (ADDR_W)
  ) cmp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr),
    .rd_iss_i    (mem_re_o),
    .addr_i      (mem_addr_o),
    .elem_i      (elem),
    .exp_i       (iss_val),
    .rdata_i     (mem_rdata_i),
    .fail_o      (fail_o),
    .fail_addr_o (fail_addr_o),
    .fail_elem_o (fail_elem_o),
    .fail_exp_o  (f_exp)
  );

  assign fail_exp_o = {DW{f_exp}};

endmodule

// File: rtl/march_bist_ctrl_chk.sv
module march_bist_ctrl_chk #(
  parameter int DW = 32,
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          mem_we_o,
  input logic          mem_re_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          fail_o,
  input logic [AW-1:0] fail_addr_o,
  input logic [2:0]    fail_elem_o
);

  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o)); // R10

  AST_WDATA_SOLID: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> ((mem_wdata_o == '0) || (mem_wdata_o == '1))); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_we_o && !mem_re_o)); // R2

  AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !done_o) |=> (busy_o && !fail_o)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o))); // R7

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !(start_i && !busy_o && !done_o)) |=> fail_o); // R6

  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !(start_i && !busy_o && !done_o)) |=>
      ($stable(fail_addr_o) && $stable(fail_elem_o))); // R6

  AST_BUSY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && (mem_we_o || mem_re_o) && start_i) |=> busy_o); // R8

endmodule

bind march_bist_ctrl march_bist_ctrl_chk #(
  .DW (DW),
  .AW (ADDR_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .mem_we_o    (mem_we_o),
  .mem_re_o    (mem_re_o),
  .mem_wdata_o (mem_wdata_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .fail_o      (fail_o),
  .fail_addr_o (fail_addr_o),
  .fail_elem_o (fail_elem_o)
);

// File: tb/march_bist_ctrl_tb_top.sv
`timescale 1ns/1ps
module march_bist_ctrl_tb_top;

  localparam int ROW_N = 8;
  localparam int COL_N = 4;
  localparam int DW    = 8;
  localparam int COL_W = 2;
  localparam int AW    = 5;
  localparam int N     = ROW_N * COL_N;
  localparam int IW    = AW + 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic          mem_we_o, mem_re_o;
  logic [DW-1:0] mem_rdata_i;
  logic          busy_o, done_o, fail_o;
  logic [AW-1:0] fail_addr_o;
  logic [2:0]    fail_elem_o;
  logic [DW-1:0] fail_exp_o;

  always #5 clk = ~clk;

  march_bist_ctrl #(.ROW_N(ROW_N), .COL_N(COL_N), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .mem_rdata_i(mem_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
    .fail_addr_o(fail_addr_o), .fail_elem_o(fail_elem_o), .fail_exp_o(fail_exp_o)
  );

  // Memory model with read-side fault masks
  logic [DW-1:0] mem [N];
  logic [DW-1:0] sa1 [N];
  logic [DW-1:0] sa0 [N];

  always_ff @(posedge clk) begin
    if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    if (mem_re_o) mem_rdata_i <= (mem[mem_addr_o] | sa1[mem_addr_o]) & ~sa0[mem_addr_o];
  end

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // item = {elem[2:0], we, val, addr}
  logic [IW-1:0] exp_q[$];
  int ops_seen;
  int last_op_cyc;
  bit done_seen;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic build_expected();
    exp_q.delete();
    for (int e = 0; e < 6; e++) begin
      bit down = (e == 3) || (e == 4);
      for (int i = 0; i < N; i++) begin
        int lin = down ? (N - 1 - i) : i;
        int row = lin / COL_N;
        int col = lin % COL_N;
        logic [AW-1:0] a = AW'((row << COL_W) | col);
        bit rv = (e == 2) || (e == 4);
        if (e == 0) begin
          exp_q.push_back({3'(e), 1'b1, 1'b0, a});
        end else if (e == 5) begin
          exp_q.push_back({3'(e), 1'b0, 1'b0, a});
        end else begin
          exp_q.push_back({3'(e), 1'b0, rv, a});
          exp_q.push_back({3'(e), 1'b1, ~rv, a});
        end
      end
    end
  endtask

  // Monitor: pops expected operations and compares them
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we_o || mem_re_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 extra op", ops_seen, 10 * N);
        end else begin
          logic [IW-1:0] it;
          it = exp_q.pop_front();
          ops_seen++;
          last_op_cyc = cyc;
          check(mem_we_o == it[AW+1], "R1 op kind", int'(mem_we_o), int'(it[AW+1]));
          check(mem_addr_o == it[AW-1:0], "R1 R3 R4 address", int'(mem_addr_o), int'(it[AW-1:0]));
          if (mem_we_o)
            check(mem_wdata_o == {DW{it[AW]}}, "R1 R10 wdata", int'(mem_wdata_o), int'({DW{it[AW]}}));
        end
      end else if (busy_o && exp_q.size() != 0) begin
        check(1'b0, "R2 idle gap", 0, 1);
      end
      if (done_o) begin
        done_seen = 1'b1;
        check(cyc - last_op_cyc == 2, "R7 done latency", cyc - last_op_cyc, 2);
        check(!busy_o, "R7 busy low at done", int'(busy_o), 0);
        check(ops_seen == 10 * N, "R2 op count", ops_seen, 10 * N);
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic clear_faults();
    for (int i = 0; i < N; i++) begin
      sa1[i] = '0;
      sa0[i] = '0;
    end
  endtask

  task automatic run(input bit mid_start, input bit exp_fail,
                     input int e_addr, input int e_elem, input bit e_val);
    int t;
    build_expected();
    ops_seen = 0;
    done_seen = 1'b0;
    pulse_start();
    if (mid_start) begin
      repeat (40) @(negedge clk);
      check(busy_o, "R8 busy before extra start", int'(busy_o), 1);
      pulse_start();
    end
    t = 0;
    while (!done_seen && t < 2000) begin
      @(negedge clk);
      t++;
    end
    check(done_seen, "R7 done seen", int'(done_seen), 1);
    check(fail_o == exp_fail, "R5 R6 fail flag", int'(fail_o), int'(exp_fail));
    if (exp_fail) begin
      check(fail_addr_o == AW'(e_addr), "R6 fail addr", int'(fail_addr_o), e_addr);
      check(fail_elem_o == 3'(e_elem), "R6 fail elem", int'(fail_elem_o), e_elem);
      check(fail_exp_o == {DW{e_val}}, "R5 fail expected word",
            int'(fail_exp_o), int'({DW{e_val}}));
    end
    @(negedge clk);
    check(!done_o, "R7 done one cycle", int'(done_o), 0);
    check(fail_o == exp_fail, "R6 fail held after done", int'(fail_o), int'(exp_fail));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    ops_seen = 0;
    last_op_cyc = 0;
    done_seen = 1'b0;
    clear_faults();
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !fail_o, "R9 reset status", int'({busy_o, done_o, fail_o}), 0);
    check(!mem_we_o && !mem_re_o, "R9 reset mem ctrl", int'({mem_we_o, mem_re_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy_o && !fail_o, "R9 after reset release", int'({busy_o, fail_o}), 0);

    // Clean memory
    run(1'b0, 1'b0, 0, 0, 1'b0);

    // Stuck-at-1 bit at word 13: caught by the first read-0 element
    sa1[13] = 8'h04;
    run(1'b0, 1'b1, 13, 1, 1'b0);

    // Clean again: start must clear the sticky flag
    clear_faults();
    run(1'b0, 1'b0, 0, 0, 1'b0);

    // Stuck-at-0 bit at word 5: first seen by element 2 reading ones
    sa0[5] = 8'h08;
    run(1'b0, 1'b1, 5, 2, 1'b1);

    // Two faulty words: the lower address is met first
    clear_faults();
    sa1[20] = 8'h80;
    sa1[7]  = 8'h01;
    run(1'b0, 1'b1, 7, 1, 1'b0);

    // Extra start during a run is ignored
    clear_faults();
    run(1'b1, 1'b0, 0, 0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule